// File: doc/BRIEF.md
# Reloadable Timer / Event Counter

An up-counting counter with a reload register, driven through a small register port. It has three ways of counting. In interval-timer mode it advances on each internal tick. In event mode it advances on each rising edge of an external pin, which is first synchronized. In pulse-width mode it advances on internal ticks only while the external pin is high. When the count steps past its all-ones value, it takes the reload value in that same step. The step also sets a sticky overflow flag and raises a one-cycle wake pulse.

Software uses address 0 for the count and reload value. It uses address 1 for the control word. A write to address 0 while the counter is stopped sets both the reload register and the count. While the counter runs, the same write updates only the reload register, and the new value takes effect at the next overflow. In pulse-width mode the run bit clears itself when the pin falls, so the measured width stays in the count. In the other two modes the run bit stays set until software clears it. A read of the count stalls counting for that cycle, so one count can be lost.

Top module: `tmr_reload`

## Requirements
- R1: After reset the count, the reload register and the control word all read 0, and irq_o and wake_o are low.
- R2: Control word at address 1: bit 0 run, bit 1 interrupt enable, bits 3:2 mode (00 timer, 01 event, 10 pulse width, 11 no counting), bit 4 overflow flag, other bits read 0. While run is 0 the count holds, except when a write to address 0 changes it.
- R3: In timer mode with run set, the count rises by one on each cycle in which tick_i is high.
- R4: In event mode the count rises by one for each rising edge of evt_i, after a two-flop synchronizer. tick_i has no effect in this mode, and the run bit stays set across overflows.
- R5: In pulse-width mode the count rises on tick_i only while the synchronized evt_i is high. When the synchronized evt_i falls, run clears by itself and the count holds the measured width.
- R6: A write to address 0 while run is 0 loads the written value into both the reload register and the count.
- R7: A write to address 0 while run is 1 leaves the count unchanged. The written value becomes the reload value used at the next overflow.
- R8: A step from 0xFF loads the reload value in that same cycle and drives wake_o high for that cycle, in every mode.
- R9: An overflow sets the flag (bit 4), which holds until software writes 0 to it. irq_o is high exactly when the flag and the interrupt-enable bit are both set, so with the enable clear no request is raised.
- R10: A cycle with rd_i high and addr_i at 0 does not count, even if a count event is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Internal count tick (prescaled) |
| evt_i | input | 1 | External event / gate pin, asynchronous |
| addr_i | input | 1 | Register select: 0 count/reload, 1 control |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (blocks counting at address 0) |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for addr_i |
| irq_o | output | 1 | Interrupt request: flag and enable |
| wake_o | output | 1 | One-cycle overflow pulse |

## Verification
The bench builds the block with its defaults: an 8-bit count and a two-stage synchronizer. At 8 bits it can sweep every reload value from 0x00 to 0xFF in timer mode, running each one through at least one overflow. For every reload value the final count and the number of wake pulses come from arithmetic. With the small synchronizer depth, the event and pulse-width paths settle within a few cycles. Directed runs then cover the edges in event mode, a full gate pulse measurement, a reload write while running, a blocked read and the flag/enable interaction.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_PULSE = 2'b10,
    MODE_IDLE  = 2'b11
  } mode_e;

  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_IE   = 1;
  localparam int unsigned CTL_MODE = 2;
  localparam int unsigned CTL_FLAG = 4;
  localparam int unsigned CTL_BITS = 5;
endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], evt_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ovf_i,
  input  logic         done_i,
  output logic         run_o,
  output logic         ie_o,
  output mode_e        mode_o,
  output logic         flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      ie_o   <= 1'b0;
      mode_o <= MODE_TIMER;
      flag_o <= 1'b0;
    end else begin
      if (wr_i) begin
        run_o  <= wdata_i[CTL_RUN];
        ie_o   <= wdata_i[CTL_IE];
        mode_o <= mode_e'(wdata_i[CTL_MODE +: 2]);
      end else if (done_i) begin
        run_o <= 1'b0;
      end
      // overflow wins over a clearing write
      if (ovf_i)     flag_o <= 1'b1;
      else if (wr_i) flag_o <= wdata_i[CTL_FLAG];
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pre_wr_i,
  input  logic         load_i,
  input  logic [W-1:0] wdata_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] pre_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  assign ovf_o = step_i & (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      pre_o <= '0;
    end else begin
      if (pre_wr_i) pre_o <= wdata_i;
      if (load_i)      cnt_o <= wdata_i;
      else if (ovf_o)  cnt_o <= pre_o;
      else if (step_i) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_reload.sv
module tmr_reload
  import tmr_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         evt_i,
  input  logic         addr_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic         gate, rise, fall;
  logic         run, ie, flag, ovf, done, src, step, blk;
  logic         cnt_wr, ctl_wr;
  mode_e        mode;
  logic [W-1:0] cnt, pre, ctl_word;

  assign cnt_wr = wr_i & ~addr_i;
  assign ctl_wr = wr_i & addr_i;
  assign blk    = rd_i & ~addr_i;

  tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .evt_i,
    .level_o(gate), .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    unique case (mode)
      MODE_TIMER: src = tick_i;
      MODE_EVENT: src = rise;
      MODE_PULSE: src = tick_i & gate;
      default:    src = 1'b0;
    endcase
  end

  assign step = run & ~blk & src;
  assign done = run & (mode == MODE_PULSE) & fall;

  tmr_ctrl #(.W(W)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(ctl_wr), .wdata_i,
    .ovf_i(ovf), .done_i(done),
    .run_o(run), .ie_o(ie), .mode_o(mode), .flag_o(flag)
  );

  tmr_count #(.W(W)) u_count (
    .clk_i, .rst_ni,
    .pre_wr_i(cnt_wr), .load_i(cnt_wr & ~run), .wdata_i,
    .step_i(step),
    .cnt_o(cnt), .pre_o(pre), .ovf_o(ovf)
  );

  always_comb begin
    ctl_word                  = '0;
    ctl_word[CTL_RUN]         = run;
    ctl_word[CTL_IE]          = ie;
    ctl_word[CTL_MODE +: 2]   = mode;
    ctl_word[CTL_FLAG]        = flag;
  end

  assign rdata_o = addr_i ? ctl_word : cnt;
  assign irq_o   = flag & ie;
  assign wake_o  = ovf;
endmodule

// File: rtl/tmr_reload_chk.sv
module tmr_reload_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         addr_i,
  input logic         wr_i,
  input logic         rd_i,
  input logic [W-1:0] wdata_i,
  input logic         wake_o,
  input logic [W-1:0] cnt,
  input logic [W-1:0] pre,
  input logic         run,
  input logic         flag,
  input logic [1:0]   mode
);
  // R2
  hold_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !(wr_i && !addr_i)) |=> $stable(cnt));

  // R6
  stopped_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && wr_i && !addr_i) |=> cnt == $past(wdata_i));

  // R8
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> cnt == $past(pre));

  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> flag);

  // R10
  read_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_i && !wr_i) |=> $stable(cnt));

  // R5
  self_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !(wr_i && addr_i)) |=> (run || $past(mode) == 2'b10));
endmodule

bind tmr_reload tmr_reload_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .wake_o,
  .cnt, .pre, .run, .flag, .mode
);

// File: tb/tmr_reload_test.sv
module tmr_reload_test;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0, evt_i = 1'b0;
  logic         addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic         irq_o, wake_o;
  int           total = 0, bad = 0;
  bit           finished = 0;

  always #10 clk_i = ~clk_i;

  tmr_reload uut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [W-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  function automatic int peek(logic a);
    addr_i = a;
    return int'(rdata_o);
  endfunction

  task automatic look(logic a, output int v);
    addr_i = a;
    #1 v = int'(rdata_o);
  endtask

  initial begin
    int v, c, ov;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    look(0, v); chk("R1 count", v, 0);
    look(1, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 wake", wake_o, 0);

    // timer sweep over every reload value
    for (int p = 0; p < 256; p++) begin
      int n;
      wr(1, 8'h02);
      wr(0, p[W-1:0]);
      look(0, v); chk("R6 stopped load", v, p);
      wr(1, 8'h03);
      n = 258 - p; c = p; ov = 0;
      for (int i = 0; i < n; i++) begin
        @(negedge clk_i); tick_i = 1'b1;
        #1 if (wake_o) ov++;
        if (c == 255) c = p; else c++;
      end
      @(negedge clk_i); tick_i = 1'b0;
      look(0, v); chk("R3 timer count", v, c);
      chk("R8 wake pulses", ov, (p == 255) ? n : 1 + (n - (256 - p)) / (256 - p));
      chk("R9 irq", irq_o, 1);
    end

    // R2 hold while stopped
    wr(1, 8'h00);
    look(0, v); c = v;
    for (int i = 0; i < 5; i++) begin @(negedge clk_i); tick_i = 1'b1; end
    @(negedge clk_i); tick_i = 1'b0;
    look(0, v); chk("R2 stopped hold", v, c);

    // R7 write while running
    wr(0, 8'h10);
    wr(0, 8'hF0);
    wr(1, 8'h01);
    wr(0, 8'h40);
    look(0, v); chk("R7 count untouched", v, 8'hF0);
    for (int i = 0; i < 16; i++) begin @(negedge clk_i); tick_i = 1'b1; end
    @(negedge clk_i); tick_i = 1'b0;
    look(0, v); chk("R7 new reload used", v, 8'h40);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    look(0, v); chk("R7 after reload", v, 8'h41);

    // R10 blocked read
    wr(1, 8'h00);
    wr(0, 8'h20);
    wr(1, 8'h01);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i); tick_i = 1'b1; addr_i = 1'b0; rd_i = (i == 2 || i == 3);
    end
    @(negedge clk_i); tick_i = 1'b0; rd_i = 1'b0;
    look(0, v); chk("R10 read blocks", v, 8'h24);

    // R4 event mode, tick held high
    wr(1, 8'h00);
    wr(0, 8'hFD);
    wr(1, 8'h05);
    tick_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i); evt_i = 1'b1;
      repeat (2) @(negedge clk_i);
      evt_i = 1'b0;
      repeat (2) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    tick_i = 1'b0;
    look(0, v); chk("R4 event count", v, 8'hFF);
    look(1, v); chk("R4 run kept", v & 1, 1);
    chk("R9 flag set", (v >> 4) & 1, 1);
    chk("R9 irq masked", irq_o, 0);
    wr(1, 8'h17);
    #1 chk("R9 irq enabled", irq_o, 1);
    wr(1, 8'h07);
    #1 chk("R9 flag cleared", irq_o, 0);

    // R5 pulse width
    wr(1, 8'h00);
    wr(0, 8'h00);
    wr(1, 8'h09);
    tick_i = 1'b1;
    repeat (5) @(negedge clk_i);
    evt_i = 1'b1;
    repeat (10) @(negedge clk_i);
    evt_i = 1'b0;
    repeat (8) @(negedge clk_i);
    tick_i = 1'b0;
    look(0, v); chk("R5 width", v, 10);
    look(1, v); chk("R5 run cleared", v & 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule